// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block collects level-sensitive interrupt requests from up to 31 peripheral sources and routes them to two hart contexts. Each source carries a 3-bit priority. Each context has its own set of enabled sources and its own priority threshold. Software programs these through a plain 32-bit register bus with separate read and write strobes. Each context has an interrupt output that is raised while at least one source qualifies for it.

An interrupt is handled in two bus operations on the context's claim/complete register. A read hands back the identifier of the best qualifying source and retires its pending request in the same access. A later write of that identifier tells the source's gateway that servicing is finished. A source line that is still asserted at that point raises a fresh request. Between the claim and the completion, the gateway ignores the line.

Top module: `plic_core`

## Requirements
- R1: Source n (1..NSRC-1) has a 3-bit priority register at byte address 4*n, held in bits 2:0 and read back in the same place. Identifier 0 does not exist. Its priority register reads 0 and writes to it are ignored.
- R2: The claim register reads 0 when the context has no qualifying source. Bit 0 of every enable word reads 0, whatever was written to it.
- R3: Context c has a 32-bit enable word at address 0x2000 + 0x80*c. Bit n enables source n for that context.
- R4: Context c has a 3-bit threshold register at 0x200000 + 0x1000*c and a claim/complete register at that address + 4. Read data appears on bus_rdata in the cycle after bus_re is asserted.
- R5: A source qualifies for context c when it is pending, enabled for c, and its priority is strictly greater than c's threshold. irq_o[c] is a register that holds the OR of the qualifying sources for c. It follows any change one clock later.
- R6: A threshold of 7 blocks every source for its context. A priority of 0 stops a source from ever qualifying, at any threshold.
- R7: A claim read returns the qualifying source with the highest priority. Among sources of equal priority, the lowest identifier wins. The read clears that source's pending bit in the same access.
- R8: A claimed source latches no new request until a completion names it. After the completion, a line that is still high sets pending again. A line that is low leaves the source idle.
- R9: A completion write naming a source that is not enabled for the writing context is ignored, and the source stays claimed.
- R10: Reset clears every priority, enable, threshold, pending and claimed bit, and drives irq_o low.
- R11: The two contexts select independently, each by its own enables and threshold, from the shared pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level request lines; bit n is source n, bit 0 unused |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| irq_o | output | NCTX | Interrupt request to each context |

## Verification
The hardest state to reach from the ports is a source that has been claimed but not yet completed while its line is still high. In that state pending must stay clear, and a completion from the wrong context must change nothing. The bench holds every line high and drains all sources by alternating claim reads between the contexts, each read checked against a priority model. It then confirms that nothing re-pends until a completion arrives, tries a completion through a context where the source is disabled, and finally sweeps all 64 priority/threshold pairs on a single pending source.

// File: rtl/plic_core.sv
module plic_core #(
  parameter int NSRC   = 32,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic [NCTX-1:0]   irq_o
);
  localparam int ID_W = $clog2(NSRC);
  localparam logic [ADDR_W-1:0] EN_BASE  = ADDR_W'(32'h2000);
  localparam logic [ADDR_W-1:0] CTX_BASE = ADDR_W'(32'h200000);
  localparam logic [PRIO_W-1:0] PRIO_MAX = '1;

  logic [PRIO_W-1:0] prio [NSRC];
  logic [NSRC-1:0]   en   [NCTX];
  logic [PRIO_W-1:0] thr  [NCTX];
  logic [NSRC-1:0]   pend, busy;
  logic [NCTX-1:0]   irq_q;

  logic [NSRC-1:0]   prio_sel;
  logic [NCTX-1:0]   en_sel, thr_sel, clm_sel;
  logic [NSRC-1:0]   elig [NCTX];
  logic [ID_W-1:0]   best_id [NCTX];
  logic [PRIO_W-1:0] best_p  [NCTX];
  logic [NSRC-1:0]   claim_mask, done_mask;
  logic [31:0]       rd_mux;

  always_comb begin
    for (int n = 0; n < NSRC; n++)
      prio_sel[n] = (bus_addr == ADDR_W'(4 * n));
    for (int c = 0; c < NCTX; c++) begin
      en_sel[c]  = (bus_addr == EN_BASE + ADDR_W'(128 * c));
      thr_sel[c] = (bus_addr == CTX_BASE + ADDR_W'(4096 * c));
      clm_sel[c] = (bus_addr == CTX_BASE + ADDR_W'(4096 * c + 4));
    end
  end

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      best_id[c] = '0;
      best_p[c]  = '0;
      for (int n = 0; n < NSRC; n++)
        elig[c][n] = pend[n] && en[c][n] && (prio[n] > thr[c]);
      for (int n = 1; n < NSRC; n++)
        if (elig[c][n] && prio[n] > best_p[c]) begin
          best_p[c]  = prio[n];
          best_id[c] = ID_W'(n);
        end
    end
  end

  always_comb begin
    claim_mask = '0;
    done_mask  = '0;
    for (int c = 0; c < NCTX; c++) begin
      if (bus_re && clm_sel[c] && best_id[c] != '0)
        claim_mask[best_id[c]] = 1'b1;
      for (int n = 1; n < NSRC; n++)
        if (bus_we && clm_sel[c] && bus_wdata == 32'(n) && en[c][n])
          done_mask[n] = 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 1; n < NSRC; n++)
      if (prio_sel[n]) rd_mux = 32'(prio[n]);
    for (int c = 0; c < NCTX; c++) begin
      if (en_sel[c])  rd_mux = 32'(en[c]);
      if (thr_sel[c]) rd_mux = 32'(thr[c]);
      if (clm_sel[c]) rd_mux = 32'(best_id[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NSRC; n++) prio[n] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
      bus_rdata <= '0;
    end else begin
      if (bus_we) begin
        for (int n = 1; n < NSRC; n++)
          if (prio_sel[n]) prio[n] <= bus_wdata[PRIO_W-1:0];
        for (int c = 0; c < NCTX; c++) begin
          if (en_sel[c])  en[c]  <= bus_wdata[NSRC-1:0] & ~NSRC'(1);
          if (thr_sel[c]) thr[c] <= bus_wdata[PRIO_W-1:0];
        end
      end
      if (bus_re) bus_rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      busy  <= '0;
      irq_q <= '0;
    end else begin
      for (int n = 1; n < NSRC; n++) begin
        if (claim_mask[n]) begin
          pend[n] <= 1'b0;
          busy[n] <= 1'b1;
        end else if (done_mask[n]) begin
          busy[n] <= 1'b0;
        end else if (src_i[n] && !busy[n]) begin
          pend[n] <= 1'b1;
        end
      end
      for (int c = 0; c < NCTX; c++)
        irq_q[c] <= |elig[c];
    end
  end

  assign irq_o = irq_q;

  assert_claim_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_mask != '0) |=> ((pend & $past(claim_mask)) == '0));

  assert_claim_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_mask));

  assert_no_relatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy & pend) == '0);

  assert_src0_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0] && !busy[0]);

  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_chk
      assert_thr_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr[c] == PRIO_MAX) |-> (best_id[c] == '0));
      assert_winner_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (best_id[c] != '0) |-> (prio[best_id[c]] > thr[c] && pend[best_id[c]]));
      assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (best_id[c] != '0) |=> irq_o[c]);
    end
  endgenerate
endmodule

// File: tb/plic_core_tb.sv
`timescale 1ns/1ps
module plic_core_tb;
  logic        clk = 0, rst_n = 0;
  logic [31:0] src = '0;
  logic [23:0] addr = '0;
  logic        we = 0, re = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int checks = 0, fails = 0;
  bit done = 0;

  int        mprio [32];
  bit [31:0] men [2];
  int        mthr [2];
  bit [31:0] mpend = '0, mbusy = '0;

  plic_core u_dut (.clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
    .bus_we(we), .bus_wdata(wdata), .bus_re(re), .bus_rdata(rdata), .irq_o(irq));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    addr = 24'(a); wdata = 32'(d); we = 1;
    @(posedge clk); @(negedge clk);
    we = 0;
  endtask

  task automatic rd(int a, output int d);
    addr = 24'(a); re = 1;
    @(posedge clk); @(negedge clk);
    d = int'(rdata); re = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int best(int c);
    int id = 0, bp = 0;
    for (int n = 1; n < 32; n++)
      if (mpend[n] && men[c][n] && mprio[n] > mthr[c] && mprio[n] > bp) begin
        bp = mprio[n]; id = n;
      end
    return id;
  endfunction

  task automatic relatch();
    for (int n = 1; n < 32; n++)
      if (src[n] && !mbusy[n]) mpend[n] = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int d, e;
    idle(3);
    rst_n = 1;
    chk("R10 irq after reset", irq, 0);
    rd(32'h14, d);        chk("R10 prio reset", d, 0);
    rd(32'h2000, d);      chk("R10 enable reset", d, 0);
    rd(32'h201000, d);    chk("R10 threshold reset", d, 0);
    rd(32'h200004, d);    chk("R2 claim empty", d, 0);

    for (int n = 0; n < 32; n++) begin
      wr(4 * n, n % 8);
      mprio[n] = (n == 0) ? 0 : n % 8;
    end
    for (int n = 0; n < 32; n++) begin
      rd(4 * n, d); chk("R1 prio readback", d, mprio[n]);
    end

    wr(32'h2000, 32'hFFFFFFFF); men[0] = 32'hFFFFFFFE;
    wr(32'h2080, 32'hAAAAAAAA); men[1] = 32'hAAAAAAAA;
    rd(32'h2000, d); chk("R2 R3 enable ctx0 bit0 zero", d, 32'hFFFFFFFE);
    rd(32'h2080, d); chk("R3 enable ctx1", d, 32'hAAAAAAAA);
    wr(32'h200000, 2); wr(32'h201000, 5);
    rd(32'h200000, d); chk("R4 threshold ctx0", d, 2);
    rd(32'h201000, d); chk("R4 threshold ctx1", d, 5);
    wr(32'h200000, 0); wr(32'h201000, 0); mthr[0] = 0; mthr[1] = 0;

    src = 32'h8;
    @(negedge clk); chk("R5 irq one cycle late", irq, 0);
    @(negedge clk); chk("R5 irq registered", irq, 3);
    mpend[3] = 1;

    src = 32'hFFFFFFFF;
    idle(3); relatch();
    for (int i = 0; i < 64; i++) begin
      int c = i % 2;
      e = best(c);
      rd(32'h200004 + 4096 * c, d);
      chk(c == 0 ? "R7 claim order ctx0" : "R11 claim order ctx1", d, e);
      if (e != 0) begin mpend[e] = 0; mbusy[e] = 1; end
    end
    idle(3);
    chk("R8 no relatch while claimed", irq, 0);

    wr(32'h201004, 14);
    idle(3);
    chk("R9 foreign completion ignored irq", irq, 0);
    rd(32'h200004, d); chk("R9 foreign completion ignored claim", d, 0);

    wr(32'h200004, 14); mbusy[14] = 0;
    idle(3); relatch();
    chk("R8 completion rearms", irq, 1);
    rd(32'h200004, d); chk("R8 reclaim after completion", d, 14);
    mpend[14] = 0; mbusy[14] = 1;

    wr(32'h200004, 7); mbusy[7] = 0;
    idle(3); relatch();
    for (int p = 0; p < 8; p++)
      for (int t = 0; t < 8; t++) begin
        wr(4 * 7, p); wr(32'h200000, t);
        @(negedge clk);
        chk("R6 priority threshold sweep", irq, {p > 0, p > t} & 2'b11);
      end
    wr(4 * 7, 7); wr(32'h200000, 0);
    rd(32'h201004, d); chk("R11 ctx1 claims shared source", d, 7);
    src = '0;
    wr(32'h201004, 7);
    idle(3);
    chk("R8 low line stays idle", irq, 0);
    rd(32'h200004, d); chk("R2 claim empty at end", d, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule